// File: doc/BRIEF.md
# Paged 32-bit Register Bridge for a 16-bit Management Port

This block sits behind a management-port slave that has already decoded Clause 22 transactions. Each transaction carries a 5-bit PHY address, a 5-bit register address, a write flag and 16 bits of write data. The block turns these into 32-bit read and write requests on a simple internal register bus with a ready handshake. Three things together form a 16-bit word address: a page register, the low PHY address bits and a pair of adjacent management registers. The block latches the two 16-bit halves of each word, so a 32-bit access takes effect as a single bus transfer.

The host first loads the page. It writes a 32-bit word by sending the upper half to the odd register and then the lower half to the even register. It reads a word by reading the even register and then the odd register. Management addresses that do not belong to the bridge go to a separate PHY port without change.

Top module: `mdio_reg_bridge`

## Requirements
- R1: A write to PHY address 0x1F, register 0x10 loads the page with write-data bits 8:0. A read of that address returns the page, zero-extended to 16 bits.
- R2: A data access uses PHY addresses 0x10 to 0x17. Its bus word address is {page, PHY address bits 2:0, register address bits 4:1}. Register address bit 0 selects the half: 0 is data bits 15:0 and 1 is data bits 31:16.
- R3: A read of an even data register issues exactly one bus read and returns bits 15:0 of the word fetched.
- R4: A read of an odd data register issues no bus access. It returns bits 31:16 of the word fetched by the latest even-register read, even if that word has changed on the bus since.
- R5: A write to an odd data register only stores its data in a holding register. It issues no bus access.
- R6: A write to an even data register issues one bus write of {holding register, write data}.
- R7: An access to PHY addresses 0x00 to 0x0F is forwarded unchanged on the PHY port. A read returns the PHY port's data.
- R8: The bus request and the PHY-port request are never active together. Forwarded accesses cause no bus access, and bridge accesses cause no PHY-port access.
- R9: After reset the page, the holding register and the read latch are 0, no request is active and no completion is signalled.
- R10: An access to PHY address 0x1F at any register other than 0x10 completes without effect. A write changes nothing and a read returns 0.
- R11: While a bus request waits for ready, the request, its address and its write data stay unchanged.
- R12: Each transaction completes with a single-cycle completion pulse. Read data is valid during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_valid | input | 1 | Decoded transaction present; held until completion |
| mgmt_write | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | PHY address |
| mgmt_reg | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_done | output | 1 | Completion pulse |
| mgmt_rdata | output | 16 | Read data, valid with mgmt_done |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 16 | Internal bus word address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ready | input | 1 | Internal bus completion |
| bus_rdata | input | 32 | Internal bus read data |
| phy_req | output | 1 | Forwarded PHY-port request |
| phy_we | output | 1 | Forwarded write flag |
| phy_addr | output | 5 | Forwarded PHY address |
| phy_reg | output | 5 | Forwarded register address |
| phy_wdata | output | 16 | Forwarded write data |
| phy_ready | input | 1 | PHY-port completion |
| phy_rdata | input | 16 | PHY-port read data |

## Verification
The hardest case to reach is proving that a high-half read returns latched data and does not fetch the word again. The bus responder in the bench owns the memory. After a low-half read, the bench overwrites the word directly in that memory, then reads the high half. The expected value is the upper half from before the overwrite, and the bus transfer count must not change. The same counter checks that a high-half write alone never reaches the bus.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
   typedef enum logic [2:0] {
      ACC_PAGE,
      ACC_CTL_NONE,
      ACC_LO,
      ACC_HI,
      ACC_PASS
   } acc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUS,
      ST_PHY,
      ST_DONE
   } br_state_e;
endpackage

// File: rtl/mdio_bridge_decode.sv
module mdio_bridge_decode
   import mdio_bridge_pkg::*;
#(
   parameter int PHY_W      = 5,
   parameter int REG_W      = 5,
   parameter int WIN_BITS   = 3,
   parameter logic [4:0] CTL_PHY  = 5'h1F,
   parameter logic [4:0] PAGE_REG = 5'h10
) (
   input  logic [PHY_W-1:0] phy,
   input  logic [REG_W-1:0] regn,
   output acc_kind_e        kind
);
   localparam int WIN_TAG_W = PHY_W - WIN_BITS;
   localparam logic [WIN_TAG_W-1:0] WIN_TAG = WIN_TAG_W'(1) << (WIN_TAG_W - 1);

   logic in_window;
   assign in_window = (phy[PHY_W-1:WIN_BITS] == WIN_TAG);

   always_comb begin
      if (phy == PHY_W'(CTL_PHY)) begin
         kind = (regn == REG_W'(PAGE_REG)) ? ACC_PAGE : ACC_CTL_NONE;
      end else if (in_window) begin
         kind = regn[0] ? ACC_HI : ACC_LO;
      end else begin
         kind = ACC_PASS;
      end
   end
endmodule

// File: rtl/mdio_bridge_regs.sv
module mdio_bridge_regs #(
   parameter int PAGE_W = 9,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_ld,
   input  logic [PAGE_W-1:0] page_din,
   input  logic              hold_ld,
   input  logic [HALF_W-1:0] hold_din,
   input  logic              rlat_ld,
   input  logic [HALF_W-1:0] rlat_din,
   output logic [PAGE_W-1:0] page,
   output logic [HALF_W-1:0] hold_hi,
   output logic [HALF_W-1:0] rlat_hi
);
   generate
      if (PAGE_W < 1 || PAGE_W > HALF_W) begin : g_bad_page
         $error("PAGE_W must lie in 1..HALF_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page    <= '0;
         hold_hi <= '0;
         rlat_hi <= '0;
      end else begin
         if (page_ld) page    <= page_din;
         if (hold_ld) hold_hi <= hold_din;
         if (rlat_ld) rlat_hi <= rlat_din;
      end
   end
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
   import mdio_bridge_pkg::*;
#(
   parameter int PAGE_W = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mgmt_valid,
   input  logic        mgmt_write,
   input  logic [4:0]  mgmt_phy,
   input  logic [4:0]  mgmt_reg,
   input  logic [15:0] mgmt_wdata,
   output logic        mgmt_done,
   output logic [15:0] mgmt_rdata,
   output logic        bus_req,
   output logic        bus_we,
   output logic [15:0] bus_addr,
   output logic [31:0] bus_wdata,
   input  logic        bus_ready,
   input  logic [31:0] bus_rdata,
   output logic        phy_req,
   output logic        phy_we,
   output logic [4:0]  phy_addr,
   output logic [4:0]  phy_reg,
   output logic [15:0] phy_wdata,
   input  logic        phy_ready,
   input  logic [15:0] phy_rdata
);
   localparam int HALF_W  = 16;
   localparam int WIN_B   = 3;
   localparam int IDX_B   = 4;
   localparam int WADDR_W = PAGE_W + WIN_B + IDX_B;

   generate
      if (WADDR_W != 16) begin : g_bad_addr
         $error("page plus window bits must form a 16-bit word address");
      end
   endgenerate

   acc_kind_e   kind;
   br_state_e   state;
   logic [PAGE_W-1:0] page;
   logic [HALF_W-1:0] hold_hi, rlat_hi, rsp_q;
   logic        accept, page_ld, hold_ld, rlat_ld;
   logic [WADDR_W-1:0] waddr;

   mdio_bridge_decode u_dec (
      .phy  (mgmt_phy),
      .regn (mgmt_reg),
      .kind (kind)
   );

   assign accept  = (state == ST_IDLE) && mgmt_valid;
   assign page_ld = accept && mgmt_write && (kind == ACC_PAGE);
   assign hold_ld = accept && mgmt_write && (kind == ACC_HI);
   assign rlat_ld = (state == ST_BUS) && bus_ready && !bus_we;
   assign waddr   = {page, mgmt_phy[WIN_B-1:0], mgmt_reg[IDX_B:1]};

   mdio_bridge_regs #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .page_ld  (page_ld),
      .page_din (mgmt_wdata[PAGE_W-1:0]),
      .hold_ld  (hold_ld),
      .hold_din (mgmt_wdata),
      .rlat_ld  (rlat_ld),
      .rlat_din (bus_rdata[31:16]),
      .page     (page),
      .hold_hi  (hold_hi),
      .rlat_hi  (rlat_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rsp_q     <= '0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         phy_we    <= 1'b0;
         phy_addr  <= '0;
         phy_reg   <= '0;
         phy_wdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (mgmt_valid) begin
               rsp_q <= '0;
               unique case (kind)
                  ACC_PAGE: begin
                     if (!mgmt_write) rsp_q <= HALF_W'(page);
                     state <= ST_DONE;
                  end
                  ACC_HI: begin
                     if (!mgmt_write) rsp_q <= rlat_hi;
                     state <= ST_DONE;
                  end
                  ACC_LO: begin
                     bus_we    <= mgmt_write;
                     bus_addr  <= waddr;
                     bus_wdata <= {hold_hi, mgmt_wdata};
                     state     <= ST_BUS;
                  end
                  ACC_PASS: begin
                     phy_we    <= mgmt_write;
                     phy_addr  <= mgmt_phy;
                     phy_reg   <= mgmt_reg;
                     phy_wdata <= mgmt_wdata;
                     state     <= ST_PHY;
                  end
                  default: state <= ST_DONE;
               endcase
            end
            ST_BUS: if (bus_ready) begin
               rsp_q <= bus_we ? '0 : bus_rdata[15:0];
               state <= ST_DONE;
            end
            ST_PHY: if (phy_ready) begin
               rsp_q <= phy_we ? '0 : phy_rdata;
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign bus_req    = (state == ST_BUS);
   assign phy_req    = (state == ST_PHY);
   assign mgmt_done  = (state == ST_DONE);
   assign mgmt_rdata = rsp_q;

   // R8
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && phy_req));

   // R11
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_done |=> !mgmt_done);

   // R1
   page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && mgmt_write && kind == ACC_PAGE |=> page == $past(mgmt_wdata[PAGE_W-1:0]));

   // R5
   hi_wr_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && kind == ACC_HI |=> mgmt_done && !bus_req);

   // R4
   hi_rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !mgmt_write && kind == ACC_HI |=> mgmt_rdata == $past(rlat_hi));
endmodule

// File: tb/mdio_reg_bridge_tb.sv
module mdio_reg_bridge_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        mgmt_valid = 0, mgmt_write = 0;
   logic [4:0]  mgmt_phy = 0, mgmt_reg = 0;
   logic [15:0] mgmt_wdata = 0;
   logic        mgmt_done;
   logic [15:0] mgmt_rdata;
   logic        bus_req, bus_we;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_ready = 0;
   logic [31:0] bus_rdata = 0;
   logic        phy_req, phy_we;
   logic [4:0]  phy_addr, phy_reg;
   logic [15:0] phy_wdata;
   logic        phy_ready = 0;
   logic [15:0] phy_rdata = 0;

   int checks = 0, bad = 0;
   int bus_cnt = 0, phy_cnt = 0;
   int bwait = 0, pwait = 0;
   logic [31:0] mem [int];
   logic [15:0] last_baddr;
   logic [31:0] last_bdata;
   logic        last_bwe;
   logic [4:0]  last_paddr, last_preg;
   logic [15:0] last_pdata;
   logic        last_pwe;
   logic        prev_wait = 0;
   logic [15:0] prev_addr = 0;

   // reference state
   int m_page = 0, m_hold = 0, m_rlat = 0;

   always #2.5 clk = ~clk;

   mdio_reg_bridge u_dut (.*);

   function automatic logic [31:0] mem_rd(input int a);
      if (mem.exists(a)) return mem[a];
      return {16'(a) ^ 16'h5A5A, ~16'(a)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // bus and PHY responders plus per-cycle checks
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_req && phy_req) begin
            bad++;
            $display("FAIL R8 actual=both expected=one");
         end
         if (prev_wait && (!bus_req || bus_addr != prev_addr)) begin
            bad++;
            $display("FAIL R11 actual=%h expected=%h", bus_addr, prev_addr);
         end
      end
      prev_wait = bus_req && !bus_ready;
      prev_addr = bus_addr;
      if (bus_ready) bus_ready = 0;
      else if (bus_req) begin
         if (bwait == 2) begin
            bwait = 0;
            bus_cnt++;
            last_baddr = bus_addr; last_bdata = bus_wdata; last_bwe = bus_we;
            bus_rdata = mem_rd(int'(bus_addr));
            if (bus_we) mem[int'(bus_addr)] = bus_wdata;
            bus_ready = 1;
         end else bwait++;
      end
      prev_wait = bus_req && !bus_ready;
      if (phy_ready) phy_ready = 0;
      else if (phy_req) begin
         if (pwait == 1) begin
            pwait = 0;
            phy_cnt++;
            last_paddr = phy_addr; last_preg = phy_reg;
            last_pdata = phy_wdata; last_pwe = phy_we;
            phy_rdata = {6'h2B, phy_addr, phy_reg};
            phy_ready = 1;
         end else pwait++;
      end
   end

   task automatic op(input logic [4:0] p, input logic [4:0] r, input logic w,
                     input logic [15:0] d, output logic [15:0] rd);
      int t = 0;
      @(negedge clk);
      mgmt_phy = p; mgmt_reg = r; mgmt_write = w; mgmt_wdata = d; mgmt_valid = 1;
      do begin
         @(negedge clk);
         t++;
      end while (!mgmt_done && t < 50);
      if (t >= 50) begin
         bad++; checks++;
         $display("FAIL R12 actual=timeout expected=done");
      end
      rd = mgmt_rdata;
      mgmt_valid = 0;
      @(negedge clk);
      checks++;
      if (mgmt_done) begin
         bad++;
         $display("FAIL R12 actual=1 expected=0");
      end
   endtask

   function automatic logic [15:0] exp_addr(input int pg, input logic [4:0] p, input logic [4:0] r);
      return 16'(pg * 128 + (p % 8) * 16 + (r / 2));
   endfunction

   initial begin
      logic [15:0] rd;
      int bc, pc, a;
      fork
         begin
            repeat (20000) @(posedge clk);
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 bus_req", bus_req, 0);
      check("R9 phy_req", phy_req, 0);
      check("R9 done", mgmt_done, 0);
      rst_n = 1;
      op(5'h1F, 5'h10, 0, 0, rd); check("R9 page", rd, 0);
      op(5'h11, 5'h01, 0, 0, rd); check("R9 rlatch", rd, m_rlat);

      // R1 page load, 9 bits
      op(5'h1F, 5'h10, 1, 16'hFFAB, rd); m_page = 'h1AB;
      op(5'h1F, 5'h10, 0, 0, rd); check("R1 page read", rd, 16'(m_page));

      // R5 / R6 / R2 32-bit write
      bc = bus_cnt;
      op(5'h15, 5'h07, 1, 16'hCAFE, rd); m_hold = 'hCAFE;
      check("R5 no bus on hi write", bus_cnt, bc);
      op(5'h15, 5'h06, 1, 16'hBEEF, rd);
      check("R6 one bus write", bus_cnt, bc + 1);
      check("R6 we", last_bwe, 1);
      check("R6 data", last_bdata, {16'(m_hold), 16'hBEEF});
      check("R2 addr", last_baddr, exp_addr(m_page, 5'h15, 5'h06));

      // R3 / R4 read with atomic latch
      bc = bus_cnt;
      op(5'h15, 5'h06, 0, 0, rd);
      check("R3 one bus read", bus_cnt, bc + 1);
      check("R3 low half", rd, 16'hBEEF);
      a = int'(exp_addr(m_page, 5'h15, 5'h06));
      mem[a] = 32'h1234_5678;
      op(5'h15, 5'h07, 0, 0, rd);
      check("R4 latched hi", rd, 16'hCAFE);
      check("R4 no bus", bus_cnt, bc + 1);

      // R2 another corner: page 0, top window slot
      op(5'h1F, 5'h10, 1, 16'h0000, rd); m_page = 0;
      op(5'h17, 5'h1E, 0, 0, rd);
      check("R2 addr corner", last_baddr, 16'h007F);
      check("R3 default low", rd, mem_rd(int'(16'h007F)) & 32'hFFFF);
      op(5'h17, 5'h1F, 0, 0, rd);
      check("R4 hi default", rd, mem_rd(int'(16'h007F)) >> 16);
      op(5'h10, 5'h00, 1, 16'h0001, rd);
      check("R2 addr base", last_baddr, 16'h0000);
      check("R6 reuse hold", last_bdata, {16'hCAFE, 16'h0001});

      // R7 / R8 passthrough
      bc = bus_cnt; pc = phy_cnt;
      op(5'h03, 5'h09, 1, 16'hA55A, rd);
      check("R7 phy write count", phy_cnt, pc + 1);
      check("R7 phy write fields", {last_pwe, last_paddr, last_preg, last_pdata}, {1'b1, 5'h03, 5'h09, 16'hA55A});
      op(5'h0F, 5'h1F, 0, 0, rd);
      check("R7 phy read", rd, {6'h2B, 5'h0F, 5'h1F});
      check("R8 no bus on pass", bus_cnt, bc);
      op(5'h12, 5'h02, 0, 0, rd);
      check("R8 no phy on bridge", phy_cnt, pc + 2);

      // R10 other control registers
      bc = bus_cnt; pc = phy_cnt;
      op(5'h1F, 5'h05, 1, 16'h00FF, rd);
      op(5'h1F, 5'h05, 0, 0, rd);
      check("R10 read zero", rd, 0);
      op(5'h1F, 5'h10, 0, 0, rd);
      check("R10 page kept", rd, 16'(m_page));
      check("R10 no bus", bus_cnt, bc);
      check("R10 no phy", phy_cnt, pc);

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule